// File: doc/BRIEF.md
# Legacy Interrupt Message Request Generator

This block converts per-function level interrupt lines into virtual-wire interrupt message requests for a PCIe-style transmit path. Each function owns one input bit. When a line has stayed high long enough, the block raises an "assert" request for that function. When the line later drops, it raises a matching "deassert" request. A request names the function and carries an 8-bit message code. The code is built from the function's selected legacy interrupt line (A, B, C or D) and from the direction of the message.

Generation for a function is allowed only while two per-function inputs are both low: its interrupt-disable bit (Command Register bit 10) and its MSI-enable bit. If a function is disabled while its virtual wire is asserted, the block releases the wire with a deassert request. When several functions have requests waiting, a round-robin arbiter picks one of them. The result is presented on a single valid/ready output. Every waiting request stays pending until the downstream side accepts it.

Top module: `intx_msg_gen`

## Requirements
- R1: Bit i of the interrupt level input belongs to function i, and every request it produces reports i on `msg_fn_o`.
- R2: An assert request appears (`msg_valid_o` high) right after the eighth consecutive rising clock edge at which an enabled function's level is high. A high run of seven cycles or fewer produces no request at all.
- R3: A deassert request is produced only for a function whose assert request was produced earlier. It follows a high-to-low transition of that function's level.
- R4: While a function's interrupt-disable bit is set, that function produces no assert request.
- R5: While a function's MSI-enable bit is set, that function produces no assert request.
- R6: The message code is 0x20 + pin for assert and 0x24 + pin for deassert. The pin is the function's 2-bit field at `pin_sel_i[2*i+1:2*i]`, with 0 = line A, 1 = B, 2 = C and 3 = D.
- R7: If a function is disabled by either bit while its wire is asserted, a deassert request is produced even though its level is still high.
- R8: Waiting requests are granted in round-robin order, starting from the function after the last one accepted. While `msg_valid_o` is high and `msg_ready_i` is low, the request is held and `msg_fn_o` and `msg_code_o` do not change.
- R9: For any one function, the deassert request is never presented before that function's assert request has been accepted.
- R10: Reset clears all qualification counts, asserted-wire state and pending requests. After reset `msg_valid_o` is low, and a high run that started before reset does not count toward qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_lvl_i | input | NUM_FN | Per-function interrupt level |
| cmd_intdis_i | input | NUM_FN | Per-function interrupt-disable bit |
| msi_en_i | input | NUM_FN | Per-function MSI-enable bit |
| pin_sel_i | input | 2*NUM_FN | Per-function legacy line select, 2 bits each |
| msg_valid_o | output | 1 | Request valid |
| msg_ready_i | input | 1 | Downstream accepts the request |
| msg_fn_o | output | FW | Function number of the request |
| msg_code_o | output | 8 | Message code |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that a function's pin field stays constant while that function has a request waiting, because the payload-stability property depends on it. The interrupt levels, the disable bits and the MSI bits may change at any time. The stimulus changes every input two time units after a rising edge. It rewrites a pin field only while its function is idle. It toggles the disable bits only while the level is either held high or held low. This covers both the disable-while-asserted path and the blocked-assert path.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam logic [7:0] CODE_ASSERT_BASE   = 8'h20;
  localparam logic [7:0] CODE_DEASSERT_BASE = 8'h24;
  typedef enum logic [1:0] {LINE_A = 2'd0, LINE_B = 2'd1, LINE_C = 2'd2, LINE_D = 2'd3} line_e;
endpackage

// File: rtl/intx_fn_tracker.sv
module intx_fn_tracker #(
  parameter int QUAL_CYCLES = 8,
  localparam int CW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic dis_i,
  input  logic msi_i,
  input  logic ack_i,
  output logic pend_o,
  output logic dsrt_o
);
  localparam logic [CW-1:0] QMAX  = CW'(QUAL_CYCLES);
  localparam logic [CW-1:0] QLAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic active_q, active_d;
  logic pend_q, pend_d;
  logic dsrt_q, dsrt_d;
  logic en, live, qual_hit;

  assign en       = !dis_i && !msi_i;
  assign live     = lvl_i && en;
  assign qual_hit = live && (cnt_q >= QLAST);

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    pend_d   = pend_q;
    dsrt_d   = dsrt_q;
    if (!live)
      cnt_d = '0;
    else if (cnt_q != QMAX)
      cnt_d = cnt_q + 1'b1;
    if (pend_q && ack_i)
      pend_d = 1'b0;
    if (!pend_q) begin
      if (!active_q && qual_hit) begin
        pend_d   = 1'b1;
        dsrt_d   = 1'b0;
        active_d = 1'b1;
      end else if (active_q && !live) begin
        pend_d   = 1'b1;
        dsrt_d   = 1'b1;
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      dsrt_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      pend_q   <= pend_d;
      dsrt_q   <= dsrt_d;
    end
  end

  assign pend_o = pend_q;
  assign dsrt_o = dsrt_q;

  AST_ASSERT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_q) && !dsrt_q) |-> $past(lvl_i && !dis_i && !msi_i)); // R4 R5
  AST_DSRT_AFTER_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_q) && dsrt_q) |-> $past(active_q)); // R3
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i) |=> (pend_q && $stable(dsrt_q))); // R8
endmodule

// File: rtl/intx_rr_arb.sv
module intx_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  ack_o
);
  logic [IW-1:0] ptr_q, ptr_d;
  logic          lock_q, lock_d;
  logic [IW-1:0] lidx_q, lidx_d;
  logic          found;
  logic [IW-1:0] sel;
  logic          fire;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && req_i[j]) begin
        found = 1'b1;
        sel   = IW'(j);
      end
    end
    if (lock_q) begin
      found = 1'b1;
      sel   = lidx_q;
    end
  end

  assign fire = found && ready_i;

  always_comb begin
    ptr_d  = ptr_q;
    lock_d = found && !ready_i;
    lidx_d = sel;
    ack_o  = '0;
    if (fire) begin
      ack_o[sel] = 1'b1;
      ptr_d      = (int'(sel) == N - 1) ? '0 : sel + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lock_q <= 1'b0;
      lidx_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      lock_q <= lock_d;
      lidx_q <= lidx_d;
    end
  end

  assign valid_o = found;
  assign idx_o   = sel;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R8
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_o & ~req_i) == '0)); // R8
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o))); // R8
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen #(
  parameter int NUM_FN      = 4,
  parameter int QUAL_CYCLES = 8,
  localparam int FW = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FN-1:0]   irq_lvl_i,
  input  logic [NUM_FN-1:0]   cmd_intdis_i,
  input  logic [NUM_FN-1:0]   msi_en_i,
  input  logic [2*NUM_FN-1:0] pin_sel_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [FW-1:0]       msg_fn_o,
  output logic [7:0]          msg_code_o
);
  import intx_pkg::*;

  logic [NUM_FN-1:0] pend, dsrt, ack;
  logic [FW-1:0]     idx;
  line_e             line;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    intx_fn_tracker #(.QUAL_CYCLES(QUAL_CYCLES)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (irq_lvl_i[g]),
      .dis_i  (cmd_intdis_i[g]),
      .msi_i  (msi_en_i[g]),
      .ack_i  (ack[g]),
      .pend_o (pend[g]),
      .dsrt_o (dsrt[g])
    );
  end

  intx_rr_arb #(.N(NUM_FN)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (pend),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .idx_o   (idx),
    .ack_o   (ack)
  );

  always_comb begin
    line       = line_e'(pin_sel_i[2*idx +: 2]);
    msg_fn_o   = idx;
    msg_code_o = (dsrt[idx] ? CODE_DEASSERT_BASE : CODE_ASSERT_BASE) + {6'b0, line};
  end

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> ($stable(msg_fn_o) && $stable(msg_code_o))); // R8
  AST_VALID_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> pend[idx]); // R1
endmodule

// File: tb/test_intx_msg_gen.sv
module test_intx_msg_gen;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] lvl, dis, msi;
  logic [7:0]    pins;
  logic          ready;
  logic          valid;
  logic [1:0]    fn;
  logic [7:0]    code;

  int n_chk = 0;
  int n_fail = 0;
  int mon_n = 0;
  int log_fn [256];
  int log_code [256];

  // entry: {fn[1:0], pin[1:0], high_len[7:0]}
  localparam logic [11:0] VEC [6] = '{
    {2'd0, 2'd0, 8'd8}, {2'd1, 2'd1, 8'd7}, {2'd2, 2'd2, 8'd20},
    {2'd3, 2'd3, 8'd1}, {2'd1, 2'd3, 8'd9}, {2'd0, 2'd2, 8'd3}
  };

  always #5 clk = ~clk;

  intx_msg_gen #(.NUM_FN(NF), .QUAL_CYCLES(8)) i_intx_msg_gen (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(lvl), .cmd_intdis_i(dis),
    .msi_en_i(msi), .pin_sel_i(pins), .msg_valid_o(valid),
    .msg_ready_i(ready), .msg_fn_o(fn), .msg_code_o(code)
  );

  always @(negedge clk) begin
    if (rst_n && valid && ready && mon_n < 256) begin
      log_fn[mon_n]   <= int'(fn);
      log_code[mon_n] <= int'(code);
      mon_n           <= mon_n + 1;
    end
  end

  task automatic cycles(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_msg(input int k, input int efn, input int ecode, input string tag);
    check(mon_n > k, {tag, " present"}, mon_n, k + 1);
    if (mon_n > k) begin
      check(log_fn[k] == efn, {tag, " fn"}, log_fn[k], efn);
      check(log_code[k] == ecode, {tag, " code"}, log_code[k], ecode);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    rst_n = 1'b0; lvl = '0; dis = '0; msi = '0; pins = '0; ready = 1'b1;
    cycles(3);
    check(valid == 1'b0, "R10 valid low in reset", valid, 0);
    rst_n = 1'b1;
    cycles(2);
    check(valid == 1'b0, "R10 valid low after reset", valid, 0);

    // table walk: R1 R2 R3 R6
    for (int v = 0; v < 6; v++) begin
      int vf, vp, vl;
      vf = int'(VEC[v][11:10]); vp = int'(VEC[v][9:8]); vl = int'(VEC[v][7:0]);
      base = mon_n;
      pins[2*vf +: 2] = 2'(vp);
      lvl[vf] = 1'b1;
      cycles(vl);
      lvl[vf] = 1'b0;
      cycles(5);
      if (vl >= 8) begin
        check(mon_n - base == 2, "R2 R3 message count", mon_n - base, 2);
        check_msg(base, vf, 8'h20 + vp, "R1 R6 assert");
        check_msg(base + 1, vf, 8'h24 + vp, "R3 R6 deassert");
      end else begin
        check(mon_n - base == 0, "R2 short pulse ignored", mon_n - base, 0);
      end
    end

    // R2 exact latency, R8 hold while not ready, R9 ordering
    ready = 1'b0; pins = 8'b11_10_01_00;
    lvl[0] = 1'b1;
    cycles(7);
    check(valid == 1'b0, "R2 not yet after 7", valid, 0);
    cycles(1);
    check(valid == 1'b1, "R2 valid after 8", valid, 1);
    check(code == 8'h20, "R6 assert line A", code, 8'h20);
    lvl[0] = 1'b0;
    cycles(5);
    check(valid && fn == 2'd0 && code == 8'h20, "R8 R9 assert held", code, 8'h20);
    base = mon_n;
    ready = 1'b1;
    cycles(4);
    check_msg(base, 0, 8'h20, "R9 assert first");
    check_msg(base + 1, 0, 8'h24, "R9 deassert second");

    // R4 interrupt-disable blocks, R5 MSI-enable blocks
    base = mon_n;
    dis[1] = 1'b1; msi[2] = 1'b1;
    lvl[1] = 1'b1; lvl[2] = 1'b1;
    cycles(12);
    check(valid == 1'b0, "R4 R5 no request while high", valid, 0);
    lvl[1] = 1'b0; lvl[2] = 1'b0;
    cycles(4);
    check(mon_n - base == 0, "R4 R5 no messages", mon_n - base, 0);
    dis[1] = 1'b0; msi[2] = 1'b0;

    // R7 disable while asserted
    base = mon_n;
    lvl[3] = 1'b1;
    cycles(10);
    dis[3] = 1'b1;
    cycles(3);
    check_msg(base, 3, 8'h23, "R7 assert");
    check_msg(base + 1, 3, 8'h27, "R7 deassert on disable");
    lvl[3] = 1'b0;
    cycles(2);
    dis[3] = 1'b0;
    base = mon_n;
    lvl[2] = 1'b1; msi[2] = 1'b0;
    cycles(9);
    msi[2] = 1'b1;
    cycles(3);
    check_msg(base + 1, 2, 8'h26, "R7 deassert on msi enable");
    lvl[2] = 1'b0; msi[2] = 1'b0;
    cycles(3);

    // R10 reset discards partial run
    base = mon_n;
    lvl[0] = 1'b1;
    cycles(5);
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(5);
    check(valid == 1'b0, "R10 count cleared by reset", valid, 0);
    lvl[0] = 1'b0;
    cycles(3);
    check(mon_n - base == 0, "R10 no messages", mon_n - base, 0);

    // R8 round robin: pointer moves past fn1, then fn3 beats fn0
    base = mon_n;
    lvl[1] = 1'b1;
    cycles(10);
    check_msg(base, 1, 8'h21, "R8 first grant");
    ready = 1'b0;
    lvl[0] = 1'b1; lvl[3] = 1'b1;
    cycles(10);
    check(valid && fn == 2'd3, "R8 rr pick", fn, 3);
    ready = 1'b1;
    cycles(4);
    check_msg(base + 1, 3, 8'h23, "R8 rr second");
    check_msg(base + 2, 0, 8'h20, "R8 rr third");
    lvl = '0;
    cycles(8);
    check(mon_n - base == 6, "R3 deasserts for all", mon_n - base, 6);

    summary();
  end
endmodule